// File: doc/BRIEF.md
# Dual-Bank Clock Divider with Output Crosspoint

This block derives six clock outputs from two source clocks: a reference and a PLL-derived clock. Each source is seen as a stream of one-cycle tick pulses on a fast system clock `clk_i`. Each divided clock is built as a 50% duty level plus a one-cycle enable pulse in the system clock domain. There are two divider banks. Each bank has one programmable modulo-N counter, and each bank can count ticks from either source.

Fixed taps are decoded from the same counter. Bank one offers a halving tap and a thirding tap. Bank two offers a halving tap and a quartering tap. Each tap gives a correct waveform only for certain divisors, so a rule checker watches the live routing. An output whose route breaks a rule is held low. Every rule break also sets a sticky error flag.

Configuration is done through a simple write port: an address, eight data bits and a write strobe. Each output is routed to the reference, to one of six divider sources, or to "off". A new route takes effect only while that output is low, so a switch never cuts a high phase short.

Top module: `clkdiv_router`

## Requirements
- R1: Register map. Address 0 sets divisor N1 and address 1 sets divisor N2, both from data bits [6:0]. Address 2 sets the bank sources from bits [1:0]: bit 0 is bank one, bit 1 is bank two, and 1 selects the PLL ticks. Addresses 3 to 8 set the route of outputs 0 to 5 from bits [2:0]. After reset both divisors are 8, both banks use the reference, every route is 7, all outputs and enables are low, and the error flag is 0.
- R2: With route 1 (/N1) or route 4 (/N2), and a legal divisor N, the output repeats every N source ticks. It is high for floor(N/2) ticks of each period.
- R3: Route 2 (bank one halving tap) and route 5 (bank two halving tap) give a period of 2 ticks with 1 tick high. Each is legal only when its bank divisor is a multiple of 4.
- R4: Route 3 (bank one thirding tap) gives a period of 3 ticks with 1 tick high. It is legal only when N1 equals 6.
- R5: Route 6 (bank two quartering tap) gives a period of 4 ticks with 2 ticks high. It is legal only when N2 is a multiple of 8.
- R6: Each bank counts the ticks of the source chosen by its bit in address 2. Writing a divisor or the source register restarts the affected bank's counter.
- R7: Route 0 copies the reference tick stream to the output one system cycle later.
- R8: Route 7 holds the output low.
- R9: A divisor outside 4..127, or a tap used with a divisor its rule forbids, holds the affected output low and sets the error flag.
- R10: When no output uses a bank, that bank's divisor must be 8. Any other value sets the error flag.
- R11: The error flag stays set until a write to address 9. A rule break that is still present sets it again on the next cycle.
- R12: A route written while its output is high takes effect only after that output goes low. The current high phase runs to its full length.
- R13: The output's enable line pulses for exactly one system cycle on each rising edge of that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle pulse per reference clock edge |
| pll_tick_i | input | 1 | One-cycle pulse per PLL clock edge |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| clk_o | output | 6 | Divided clock levels, one bit per output |
| en_o | output | 6 | One-cycle pulse on each output's rising edge |
| cfg_err_o | output | 1 | Sticky configuration rule violation flag |

## Verification
- **Counter faults.** A wrong counter wrap or phase decode changes the measured high time or period of the affected output. This shows within one output period after the counter restarts.
- **Rule-checker faults.** A wrong rule either lets a forbidden tap toggle or holds a legal tap low. Either way, the output shows it within one period.
- **Routing faults.** A wrong route-update guard shortens the high phase that was running when the route was written.
- **Error-flag faults.** A wrong sticky flag shows at `cfg_err_o` one cycle after a violating write, or one cycle after a clear.

// File: rtl/clkdiv_router_pkg.sv
package clkdiv_router_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned NSRC  = 1 << SEL_W;

  localparam int unsigned ADR_N1   = 0;
  localparam int unsigned ADR_N2   = 1;
  localparam int unsigned ADR_BSRC = 2;
  localparam int unsigned ADR_SEL0 = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_REF   = 3'd0,
    SRC_B1_N  = 3'd1,
    SRC_B1_D2 = 3'd2,
    SRC_B1_D3 = 3'd3,
    SRC_B2_N  = 3'd4,
    SRC_B2_D2 = 3'd5,
    SRC_B2_D4 = 3'd6,
    SRC_OFF   = 3'd7
  } src_sel_e;
endpackage

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int unsigned DIV_W    = 7,
  parameter bit          HAS_DIV3 = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             lvl_n_o,
  output logic             lvl_half_o,
  output logic             lvl_tap_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (DIV_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= (cnt_inc >= {1'b0, div_i}) ? '0 : cnt_inc[DIV_W-1:0];
  end

  assign lvl_n_o    = cnt_q < (div_i >> 1);
  assign lvl_half_o = ~cnt_q[0];

  // third tap assumes N=6, quarter tap assumes N%8==0
  if (HAS_DIV3) begin : g_div3
    assign lvl_tap_o = (cnt_q == '0) || (cnt_q == DIV_W'(3));
  end else begin : g_div4
    assign lvl_tap_o = ~cnt_q[1];
  end
endmodule

// File: rtl/clkdiv_rule_chk.sv
module clkdiv_rule_chk
  import clkdiv_router_pkg::*;
#(
  parameter int unsigned N_OUT    = 6,
  parameter int unsigned DIV_W    = 7,
  parameter int unsigned DIV_MIN  = 4,
  parameter int unsigned DIV_MAX  = 127,
  parameter int unsigned DIV_IDLE = 8
) (
  input  logic [DIV_W-1:0] n1_i,
  input  logic [DIV_W-1:0] n2_i,
  input  logic [SEL_W-1:0] sel_i [N_OUT],
  output logic [N_OUT-1:0] bad_o,
  output logic             viol_o
);
  logic n1_ok, n2_ok, b1_used, b2_used;

  assign n1_ok = ({1'b0, n1_i} >= (DIV_W+1)'(DIV_MIN)) && ({1'b0, n1_i} <= (DIV_W+1)'(DIV_MAX));
  assign n2_ok = ({1'b0, n2_i} >= (DIV_W+1)'(DIV_MIN)) && ({1'b0, n2_i} <= (DIV_W+1)'(DIV_MAX));

  always_comb begin
    b1_used = 1'b0;
    b2_used = 1'b0;
    for (int k = 0; k < N_OUT; k++) begin
      unique case (src_sel_e'(sel_i[k]))
        SRC_B1_N:  bad_o[k] = !n1_ok;
        SRC_B1_D2: bad_o[k] = !n1_ok || (n1_i[1:0] != 2'b00);
        SRC_B1_D3: bad_o[k] = (n1_i != DIV_W'(6));
        SRC_B2_N:  bad_o[k] = !n2_ok;
        SRC_B2_D2: bad_o[k] = !n2_ok || (n2_i[1:0] != 2'b00);
        SRC_B2_D4: bad_o[k] = !n2_ok || (n2_i[2:0] != 3'b000);
        default:   bad_o[k] = 1'b0;
      endcase
      if (sel_i[k] inside {SRC_B1_N, SRC_B1_D2, SRC_B1_D3}) b1_used = 1'b1;
      if (sel_i[k] inside {SRC_B2_N, SRC_B2_D2, SRC_B2_D4}) b2_used = 1'b1;
    end
  end

  assign viol_o = (|bad_o)
               || (!b1_used && (n1_i != DIV_W'(DIV_IDLE)))
               || (!b2_used && (n2_i != DIV_W'(DIV_IDLE)));
endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage
  import clkdiv_router_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_req_i,
  input  logic [NSRC-1:0]  src_i,
  input  logic             bad_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             clk_o,
  output logic             en_o
);
  logic [SEL_W-1:0] sel_q;
  logic             lvl, clk_q, en_q;

  assign lvl = src_i[sel_q] & ~bad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SRC_OFF;
      clk_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (!clk_q) sel_q <= sel_req_i;  // switch only in low phase
      clk_q <= lvl;
      en_q  <= lvl & ~clk_q;
    end
  end

  assign sel_o = sel_q;
  assign clk_o = clk_q;
  assign en_o  = en_q;
endmodule

// File: rtl/clkdiv_router.sv
module clkdiv_router
  import clkdiv_router_pkg::*;
#(
  parameter int unsigned N_OUT    = 6,
  parameter int unsigned DIV_W    = 7,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DIV_MIN  = 4,
  parameter int unsigned DIV_MAX  = 127,
  parameter int unsigned DIV_IDLE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              pll_tick_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [N_OUT-1:0]  clk_o,
  output logic [N_OUT-1:0]  en_o,
  output logic              cfg_err_o
);
  localparam int unsigned ADR_CLR = ADR_SEL0 + N_OUT;

  logic [DIV_W-1:0] n1_q, n2_q;
  logic [1:0]       bsrc_q;
  logic [SEL_W-1:0] sel_req [N_OUT];
  logic [SEL_W-1:0] sel_act [N_OUT];
  logic [N_OUT-1:0] out_bad;
  logic             viol, err_q, err_clr;
  logic             wr_n1, wr_n2, wr_bsrc;
  logic             b1_n, b1_d2, b1_d3, b2_n, b2_d2, b2_d4;
  logic [NSRC-1:0]  src_lvl;
  logic             unused_wdata;

  assign unused_wdata = ^cfg_wdata_i[DATA_W-1:DIV_W];

  assign wr_n1   = cfg_we_i && (cfg_addr_i == ADDR_W'(ADR_N1));
  assign wr_n2   = cfg_we_i && (cfg_addr_i == ADDR_W'(ADR_N2));
  assign wr_bsrc = cfg_we_i && (cfg_addr_i == ADDR_W'(ADR_BSRC));
  assign err_clr = cfg_we_i && (cfg_addr_i == ADDR_W'(ADR_CLR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n1_q   <= DIV_W'(DIV_IDLE);
      n2_q   <= DIV_W'(DIV_IDLE);
      bsrc_q <= 2'b00;
      err_q  <= 1'b0;
    end else begin
      if (wr_n1)   n1_q   <= cfg_wdata_i[DIV_W-1:0];
      if (wr_n2)   n2_q   <= cfg_wdata_i[DIV_W-1:0];
      if (wr_bsrc) bsrc_q <= cfg_wdata_i[1:0];
      err_q <= (err_q & ~err_clr) | viol;
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_req[k] <= SRC_OFF;
      else if (cfg_we_i && (cfg_addr_i == ADDR_W'(ADR_SEL0 + k)))
        sel_req[k] <= cfg_wdata_i[SEL_W-1:0];
    end
  end

  clkdiv_bank #(.DIV_W(DIV_W), .HAS_DIV3(1'b1)) u_bank1 (
    .clk_i, .rst_ni,
    .tick_i    (bsrc_q[0] ? pll_tick_i : ref_tick_i),
    .restart_i (wr_n1 | wr_bsrc),
    .div_i     (n1_q),
    .lvl_n_o   (b1_n),
    .lvl_half_o(b1_d2),
    .lvl_tap_o (b1_d3)
  );

  clkdiv_bank #(.DIV_W(DIV_W), .HAS_DIV3(1'b0)) u_bank2 (
    .clk_i, .rst_ni,
    .tick_i    (bsrc_q[1] ? pll_tick_i : ref_tick_i),
    .restart_i (wr_n2 | wr_bsrc),
    .div_i     (n2_q),
    .lvl_n_o   (b2_n),
    .lvl_half_o(b2_d2),
    .lvl_tap_o (b2_d4)
  );

  assign src_lvl = {1'b0, b2_d4, b2_d2, b2_n, b1_d3, b1_d2, b1_n, ref_tick_i};

  clkdiv_rule_chk #(
    .N_OUT(N_OUT), .DIV_W(DIV_W), .DIV_MIN(DIV_MIN),
    .DIV_MAX(DIV_MAX), .DIV_IDLE(DIV_IDLE)
  ) u_rules (
    .n1_i  (n1_q),
    .n2_i  (n2_q),
    .sel_i (sel_act),
    .bad_o (out_bad),
    .viol_o(viol)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    clkdiv_out_stage u_out (
      .clk_i, .rst_ni,
      .sel_req_i(sel_req[k]),
      .src_i    (src_lvl),
      .bad_i    (out_bad[k]),
      .sel_o    (sel_act[k]),
      .clk_o    (clk_o[k]),
      .en_o     (en_o[k])
    );
  end

  assign cfg_err_o = err_q;
endmodule

// File: rtl/clkdiv_router_chk.sv
module clkdiv_router_chk
  import clkdiv_router_pkg::*;
#(
  parameter int unsigned N_OUT = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_OUT-1:0] clk_o,
  input logic [N_OUT-1:0] en_o,
  input logic             cfg_err_o,
  input logic [SEL_W-1:0] sel_act [N_OUT],
  input logic [N_OUT-1:0] out_bad,
  input logic             viol,
  input logic             err_clr
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_k
    assert_bad_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_bad[k] |=> !clk_o[k]);
    assert_off_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_act[k] == SRC_OFF) |=> !clk_o[k]);
    assert_switch_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sel_act[k]) |-> !$past(clk_o[k]));
    assert_en_on_rise_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o[k] |-> (clk_o[k] && !$past(clk_o[k])));
    assert_rise_has_en_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_o[k]) |-> en_o[k]);
  end

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_err_o) && !$past(err_clr)) |-> cfg_err_o);
  assert_viol_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol |=> cfg_err_o);
endmodule

bind clkdiv_router clkdiv_router_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i, .rst_ni, .clk_o, .en_o, .cfg_err_o,
  .sel_act, .out_bad, .viol, .err_clr
);

// File: tb/clkdiv_router_tb.sv
module clkdiv_router_tb_top;
  localparam int NO = 6;
  localparam int TP_REF = 4;
  localparam int TP_PLL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_tick = 1'b0, pll_tick = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [NO-1:0] clk_o, en_o;
  logic          err_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  clkdiv_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .pll_tick_i(pll_tick),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .clk_o(clk_o), .en_o(en_o), .cfg_err_o(err_o)
  );

  initial begin
    int rc = 0, pc = 0;
    forever begin
      @(posedge clk);
      ref_tick <= (rc == 0);
      pll_tick <= (pc == 0);
      rc = (rc + 1) % TP_REF;
      pc = (pc + 1) % TP_PLL;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  // find a rising edge, then measure high time, period and enable pulses
  task automatic measure(input int k, input int tmo, output bit rose,
                         output int hi, output int per, output int ens);
    bit prv, seen_low;
    rose = 0; hi = 0; per = 0; ens = 0;
    prv = clk_o[k];
    for (int i = 0; i < tmo && !rose; i++) begin
      @(negedge clk);
      if (clk_o[k] && !prv) rose = 1;
      prv = clk_o[k];
    end
    if (!rose) return;
    hi = 1; per = 1; ens = int'(en_o[k]); seen_low = 0;
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if (!clk_o[k]) seen_low = 1;
      else if (seen_low) break;
      else hi++;
      per++;
      ens += int'(en_o[k]);
    end
  endtask

  function automatic bit in_rng(input int n);
    return (n >= 4) && (n <= 127);
  endfunction

  initial begin
    bit rose; int hi, per, ens;
    int nl[16] = '{0, 3, 4, 5, 6, 7, 8, 9, 12, 13, 16, 24, 31, 40, 126, 127};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(clk_o == '0, "R1 clk_o reset", int'(clk_o), 0);
    check(en_o == '0, "R1 en_o reset", int'(en_o), 0);
    check(err_o == 1'b0, "R1 err reset", int'(err_o), 0);

    // R7 reference route on output 5
    wr(3 + 5, 0);
    repeat (10) @(negedge clk);
    measure(5, 40, rose, hi, per, ens);
    check(rose && per == TP_REF, "R7 ref period", per, TP_REF);
    check(hi == 1, "R7 ref high", hi, 1);
    wr(3 + 5, 7);
    repeat (4) @(negedge clk);
    // R8 off route
    check(clk_o[5] == 1'b0, "R8 off low", int'(clk_o[5]), 0);

    // R6 bank one on PLL ticks
    wr(2, 1); wr(0, 10); wr(3 + 0, 1);
    repeat (80) @(negedge clk);
    measure(0, 200, rose, hi, per, ens);
    check(rose && per == 10 * TP_PLL, "R6 pll period", per, 10 * TP_PLL);
    check(hi == 5 * TP_PLL, "R6 pll high", hi, 5 * TP_PLL);

    // R12 route change during high phase keeps full high
    wr(2, 0);
    repeat (100) @(negedge clk);
    measure(0, 200, rose, hi, per, ens);
    if (rose) begin
      @(negedge clk);
      we = 1'b1; addr = 4'(3); wdata = 8'd7;
      @(negedge clk);
      we = 1'b0;
      hi = 1;
      // count this and remaining high samples from the rise
      hi += int'(clk_o[0]);
      while (clk_o[0] && hi < 200) begin
        @(negedge clk);
        hi += int'(clk_o[0]);
      end
      hi = hi + 1;
    end
    check(rose && hi == 5 * TP_REF, "R12 high phase kept", hi, 5 * TP_REF);
    repeat (60) @(negedge clk);
    check(clk_o[0] == 1'b0, "R12 new route off", int'(clk_o[0]), 0);

    // R10/R11 error flag
    wr(0, 8); wr(1, 8); wr(9, 0);
    repeat (3) @(negedge clk);
    check(err_o == 1'b0, "R11 clear", int'(err_o), 0);
    wr(1, 12);
    repeat (2) @(negedge clk);
    check(err_o == 1'b1, "R10 unused bank not 8", int'(err_o), 1);
    wr(1, 8);
    repeat (3) @(negedge clk);
    check(err_o == 1'b1, "R11 sticky", int'(err_o), 1);
    wr(9, 0);
    repeat (2) @(negedge clk);
    check(err_o == 1'b0, "R11 cleared", int'(err_o), 0);
    wr(3 + 0, 1); wr(0, 3);
    repeat (2) @(negedge clk);
    check(err_o == 1'b1, "R9 range error", int'(err_o), 1);
    repeat (40) @(negedge clk);
    check(clk_o[0] == 1'b0, "R9 range held low", int'(clk_o[0]), 0);

    // sweep: out0 /N1, out1 b1/2, out2 b1/3 (ref); out3 /N2, out4 b2/2, out5 b2/4 (pll)
    wr(2, 2);
    for (int k = 0; k < NO; k++) wr(3 + k, k + 1);
    foreach (nl[j]) begin
      int n = nl[j];
      wr(0, n); wr(1, n);
      repeat (2 * n * TP_REF + 20) @(negedge clk);
      for (int k = 0; k < NO; k++) begin
        bit legal; int tp, eh, ep; string rq;
        tp = (k < 3) ? TP_REF : TP_PLL;
        case (k)
          0, 3: begin legal = in_rng(n); ep = n * tp; eh = (n / 2) * tp; rq = "R2"; end
          1, 4: begin legal = in_rng(n) && (n % 4 == 0); ep = 2 * tp; eh = tp; rq = "R3"; end
          2:    begin legal = (n == 6); ep = 3 * tp; eh = tp; rq = "R4"; end
          default: begin legal = in_rng(n) && (n % 8 == 0); ep = 4 * tp; eh = 2 * tp; rq = "R5"; end
        endcase
        measure(k, 3 * n * TP_REF + 40, rose, hi, per, ens);
        if (legal) begin
          check(rose && per == ep, $sformatf("%s period n=%0d out%0d", rq, n, k), per, ep);
          check(hi == eh, $sformatf("%s high n=%0d out%0d", rq, n, k), hi, eh);
          check(ens == 1, $sformatf("R13 enable n=%0d out%0d", n, k), ens, 1);
        end else begin
          check(!rose, $sformatf("R9 %s held low n=%0d out%0d", rq, n, k), int'(rose), 0);
          check(err_o == 1'b1, $sformatf("R9 err n=%0d out%0d", n, k), int'(err_o), 1);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule